// File: doc/BRIEF.md
# Parking PCI Bus Arbiter

This block decides which of four PCI initiators may drive the bus. Index 0 is the internal PCI-to-AHB bridge. Indices 1 to 3 are external masters. Each initiator raises an active-low request and receives an active-low grant. The arbiter watches FRAME# and IRDY# to tell when the bus is idle. A free bus stays granted to whichever initiator held it last. When ownership moves from one initiator to another, every grant is withdrawn for one clock first.

A granted initiator that keeps requesting but never starts a cycle within 16 idle clocks is declared broken. Its sticky status bit is set, its grant is withdrawn, and the bus can go to someone else. A broken external master stays locked out until its enable input goes from low to high. The bridge is only logged and is never locked out. Each enable input also masks its external master's request while the enable is low.

Software clears the status bits through a write-one-to-clear pulse vector. An interrupt output combines the status bits with a mask.

Top module: `pci_park_arbiter`

## Requirements
- R1: When no initiator is requesting, the grant held by the current owner stays asserted unchanged from clock to clock (bus parking).
- R2: At most one grant is low at any time. Whenever ownership moves to a different initiator, all grants are high for exactly one clock between the old grant and the new one.
- R3: Consider a granted initiator that is requesting, has not driven FRAME# low since its grant, and sees FRAME# and IRDY# both high. On the 16th consecutive such clock edge, its grant goes high and its status bit (bit k of `brk_status` for initiator k) goes to 1 at that same edge.
- R4: After a broken event the next grant goes to another eligible requester. The search runs round robin, starting at the index after the broken owner.
- R5: An external initiator that was declared broken has its request ignored until bit k-1 of `ext_en` is seen low and then high. After that edge it competes normally again.
- R6: A broken event on index 0 (the bridge) sets status bit 0, but the bridge stays eligible. If it is the only requester, it is granted again right after the idle clock.
- R7: While `ext_en[k-1]` is low, the request of external initiator k is ignored.
- R8: A handover happens when another eligible request is pending, the bus is idle, and the owner has either stopped requesting or has started a transaction since its grant. The winner is the first eligible index found scanning upward, modulo 4, from the owner. With all four requesting, grants therefore cycle 2, 3, 0, 1 after owner 1.
- R9: A 1 on `brk_clr[k]` clears status bit k at the next edge unless a broken event sets it at that same edge. `irq` is high exactly when some status bit is 1 and its `irq_mask` bit is 1.
- R10: After reset the bridge is parked (`gnt_n` = 4'b1110), all status bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | N_MST | Active-low requests, index 0 is the bridge |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| ext_en | input | N_MST-1 | Enable for external initiators 1..N_MST-1 (bit k-1 for index k) |
| brk_clr | input | N_MST | Write-one-to-clear pulses for the status bits |
| irq_mask | input | N_MST | Interrupt mask, 1 lets a status bit through |
| gnt_n | output | N_MST | Active-low grants |
| brk_status | output | N_MST | Sticky broken-initiator status bits |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an external initiator that is locked out while its request stays low, and then brought back by an enable edge. The stimulus grants initiator 2 and leaves it silent for 16 idle clocks while initiator 1 waits. The bench then confirms that the grant moves to 1 by round robin. Initiator 1 runs one cycle and parks, and the bench checks that the still-requesting initiator 2 never wins. Finally the bench pulses the enable low and then high, and expects the grant to reach 2 three clocks later.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

  typedef enum logic {
    ST_OWN  = 1'b0,
    ST_TURN = 1'b1
  } arb_state_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] win,
  output logic          any
);

  // scan upward from the index after last, wrapping, last itself tried last
  always_comb begin
    win = last;
    any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!any && cand[j]) begin
        any = 1'b1;
        win = IW'(j);
      end
    end
  end

endmodule

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
  parameter int TMO = 16,
  parameter int CW  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count,
  output logic expire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = count && !clear && (cnt_q == CW'(TMO - 1));

  always_comb begin
    cnt_en = clear || count;
    if (clear || expire) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/arb_master_slot.sv
module arb_master_slot #(
  parameter bit BRIDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic en,
  input  logic brk_set,
  input  logic brk_clr,
  output logic elig,
  output logic parkable,
  output logic status
);

  logic status_q, status_d;

  always_comb begin
    status_d = brk_set | (status_q & ~brk_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status = status_q;

  generate
    if (BRIDGE) begin : g_bridge
      // never taken out of service, no enable gating
      assign elig     = ~req_n;
      assign parkable = 1'b1;
    end else begin : g_ext
      logic en_q;
      logic lock_q, lock_d;
      logic en_rise;

      assign en_rise = en & ~en_q;

      always_comb begin
        if (brk_set)      lock_d = 1'b1;
        else if (en_rise) lock_d = 1'b0;
        else              lock_d = lock_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q   <= 1'b0;
          lock_q <= 1'b0;
        end else begin
          en_q   <= en;
          lock_q <= lock_d;
        end
      end

      assign elig     = ~req_n & en & ~lock_q;
      assign parkable = ~lock_q;
    end
  endgenerate

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter
  import pci_arb_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int TMO   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [N_MST-2:0] ext_en,
  input  logic [N_MST-1:0] brk_clr,
  input  logic [N_MST-1:0] irq_mask,
  output logic [N_MST-1:0] gnt_n,
  output logic [N_MST-1:0] brk_status,
  output logic             irq
);

  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;
  localparam int CW = $clog2(TMO + 1);

  logic rst_n_i;

  arb_state_e      state_q, state_d;
  logic [IW-1:0]   owner_q, owner_d;
  logic            started_q, started_d;

  logic [N_MST-1:0] elig, parkable, brk_set, own_oh;
  logic [IW-1:0]    rr_win;
  logic             rr_any;
  logic             bus_idle, in_own, owner_req, others_pending;
  logic             waiting, handoff, expire, tmr_clear;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign own_oh         = {{(N_MST-1){1'b0}}, 1'b1} << owner_q;
  assign bus_idle       = frame_n & irdy_n;
  assign in_own         = (state_q == ST_OWN);
  assign owner_req      = elig[owner_q];
  assign others_pending = |(elig & ~own_oh);
  assign waiting        = in_own & owner_req & ~started_q & bus_idle;
  assign tmr_clear      = ~in_own | ~frame_n | ~owner_req;
  assign handoff        = in_own & others_pending & bus_idle & (~owner_req | started_q);
  assign brk_set        = expire ? own_oh : '0;

  arb_idle_timer #(.TMO(TMO), .CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .clear  (tmr_clear),
    .count  (waiting),
    .expire (expire)
  );

  genvar k;
  generate
    for (k = 0; k < N_MST; k++) begin : g_slot
      if (k == 0) begin : g_br
        arb_master_slot #(.BRIDGE(1'b1)) u_slot (
          .clk      (clk),
          .rst_n    (rst_n_i),
          .req_n    (req_n[k]),
          .en       (1'b1),
          .brk_set  (brk_set[k]),
          .brk_clr  (brk_clr[k]),
          .elig     (elig[k]),
          .parkable (parkable[k]),
          .status   (brk_status[k])
        );
      end else begin : g_ex
        arb_master_slot #(.BRIDGE(1'b0)) u_slot (
          .clk      (clk),
          .rst_n    (rst_n_i),
          .req_n    (req_n[k]),
          .en       (ext_en[k-1]),
          .brk_set  (brk_set[k]),
          .brk_clr  (brk_clr[k]),
          .elig     (elig[k]),
          .parkable (parkable[k]),
          .status   (brk_status[k])
        );
      end
      assign gnt_n[k] = ~(in_own && (owner_q == IW'(k)));
    end
  endgenerate

  arb_rr_pick #(.N(N_MST), .IW(IW)) u_pick (
    .cand (elig),
    .last (owner_q),
    .win  (rr_win),
    .any  (rr_any)
  );

  always_comb begin
    state_d   = state_q;
    owner_d   = owner_q;
    started_d = started_q;
    case (state_q)
      ST_OWN: begin
        started_d = started_q | ~frame_n;
        if (expire || handoff) state_d = ST_TURN;
      end
      default: begin
        state_d   = ST_OWN;
        started_d = 1'b0;
        if (rr_any)                 owner_d = rr_win;
        else if (!parkable[owner_q]) owner_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_OWN;
      owner_q   <= '0;
      started_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      owner_q   <= owner_d;
      started_q <= started_d;
    end
  end

  assign irq = |(brk_status & irq_mask);

endmodule

// File: rtl/pci_park_arbiter_chk.sv
module pci_park_arbiter_chk #(
  parameter int N_MST = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req_n,
  input logic [N_MST-1:0] brk_clr,
  input logic [N_MST-1:0] gnt_n,
  input logic [N_MST-1:0] brk_status
);

  // R2: never two grants at once
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R2: a grant may only follow an all-released clock or repeat itself
  p_idle_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != '1 && $past(gnt_n) != '1) |-> gnt_n == $past(gnt_n));

  // R1: without requests the held grant stays put
  p_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_n) == '1 && $past(gnt_n) != '1) |-> gnt_n == $past(gnt_n));

  genvar k;
  generate
    for (k = 0; k < N_MST; k++) begin : g_k
      // R3: a fresh broken flag coincides with all grants released
      p_brk_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_status[k]) |-> gnt_n == '1);
      // R9: status holds until cleared
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(brk_status[k]) && !$past(brk_clr[k])) |-> brk_status[k]);
    end
  endgenerate

endmodule

bind pci_park_arbiter pci_park_arbiter_chk #(.N_MST(N_MST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_n      (req_n),
  .brk_clr    (brk_clr),
  .gnt_n      (gnt_n),
  .brk_status (brk_status)
);

// File: tb/pci_park_arbiter_bench.sv
module pci_park_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_n;
  logic       frame_n, irdy_n;
  logic [2:0] ext_en;
  logic [3:0] brk_clr, irq_mask;
  logic [3:0] gnt_n, brk_status;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int         exp_q[$];
  bit         mon_en = 1'b0;
  logic [3:0] mon_prev;

  always #2 clk = ~clk;

  pci_park_arbiter u_pci_park_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ext_en(ext_en), .brk_clr(brk_clr), .irq_mask(irq_mask),
    .gnt_n(gnt_n), .brk_status(brk_status), .irq(irq)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] g_of(int m);
    return ~(4'b0001 << m);
  endfunction

  // scoreboard monitor: each new grant pops one expected owner
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && gnt_n != 4'hF && gnt_n != mon_prev) begin
        if (exp_q.size() == 0) chk("R8 unexpected grant", {4'h0, gnt_n}, 8'hFF);
        else chk("R8 rotation", {4'h0, gnt_n}, {4'h0, g_of(exp_q.pop_front())});
        mon_prev = gnt_n;
      end
    end
  end

  task automatic serve_owner();
    logic [3:0] old;
    old = gnt_n;
    frame_n = 1'b0;
    tick(1);
    frame_n = 1'b1;
    for (int w = 0; w < 12; w++) begin
      if (gnt_n != 4'hF && gnt_n != old) break;
      tick(1);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1;
    ext_en = 3'b000; brk_clr = 4'h0; irq_mask = 4'hF;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk("R10 gnt", {4'h0, gnt_n}, 8'h0E);
    chk("R10 status", {4'h0, brk_status}, 8'h00);
    chk("R10 irq", {7'h0, irq}, 8'h00);

    // R7: masked external request
    req_n = 4'b1101;
    tick(3);
    chk("R7 masked", {4'h0, gnt_n}, 8'h0E);

    // R3 / R6: bridge requests and never starts
    req_n = 4'b1100;
    tick(15);
    chk("R3 before limit", {4'h0, gnt_n}, 8'h0E);
    chk("R3 status before", {4'h0, brk_status}, 8'h00);
    tick(1);
    chk("R3 gnt released", {4'h0, gnt_n}, 8'h0F);
    chk("R3 status set", {4'h0, brk_status}, 8'h01);
    chk("R9 irq on", {7'h0, irq}, 8'h01);
    tick(1);
    chk("R6 bridge regranted", {4'h0, gnt_n}, 8'h0E);
    req_n = 4'b1101;
    brk_clr = 4'b0001;
    tick(1);
    brk_clr = 4'b0000;
    chk("R9 cleared", {4'h0, brk_status}, 8'h00);
    chk("R9 irq off", {7'h0, irq}, 8'h00);

    // R2 / R1: enable master 1, idle gap then grant, then parking
    ext_en = 3'b001;
    tick(1);
    chk("R2 gap", {4'h0, gnt_n}, 8'h0F);
    tick(1);
    chk("R2 new grant", {4'h0, gnt_n}, 8'h0D);
    frame_n = 1'b0;
    tick(1);
    frame_n = 1'b1;
    req_n = 4'hF;
    tick(5);
    chk("R1 parked", {4'h0, gnt_n}, 8'h0D);

    // R4: master 2 granted, stays silent while 1 waits
    ext_en = 3'b011;
    req_n = 4'b1011;
    tick(2);
    chk("R4 grant 2", {4'h0, gnt_n}, 8'h0B);
    req_n = 4'b1001;
    tick(16);
    chk("R4 released", {4'h0, gnt_n}, 8'h0F);
    chk("R4 status", {4'h0, brk_status}, 8'h04);
    tick(1);
    chk("R4 passed to 1", {4'h0, gnt_n}, 8'h0D);

    // R5: master 1 runs and parks; locked master 2 keeps requesting
    frame_n = 1'b0;
    tick(1);
    frame_n = 1'b1;
    req_n = 4'b1011;
    tick(6);
    chk("R5 locked ignored", {4'h0, gnt_n}, 8'h0D);

    irq_mask = 4'b1011;
    tick(1);
    chk("R9 masked irq", {7'h0, irq}, 8'h00);
    irq_mask = 4'hF;
    tick(1);
    chk("R9 unmasked irq", {7'h0, irq}, 8'h01);
    brk_clr = 4'b0100;
    tick(1);
    brk_clr = 4'b0000;
    chk("R9 clear bit2", {4'h0, brk_status}, 8'h00);

    ext_en = 3'b001;
    tick(1);
    ext_en = 3'b011;
    tick(3);
    chk("R5 reenabled", {4'h0, gnt_n}, 8'h0B);

    // R8: everyone requests, scoreboard tracks rotation
    ext_en = 3'b111;
    req_n = 4'b0000;
    mon_prev = gnt_n;
    exp_q.push_back(3);
    exp_q.push_back(0);
    exp_q.push_back(1);
    exp_q.push_back(2);
    mon_en = 1'b1;
    for (int s = 0; s < 4; s++) serve_owner();
    req_n = 4'hF;
    tick(1);
    mon_en = 1'b0;
    chk("R8 all grants seen", 8'(exp_q.size()), 8'h00);
    tick(4);
    chk("R1 parked on 2", {4'h0, gnt_n}, 8'h0B);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule